// File: doc/BRIEF.md
# Pin Event Flag and Request Detector

This block watches a bank of asynchronous digital input pins and raises a per-pin event flag when the pin shows the event its 4-bit trigger code selects. The event can be a rising edge, a falling edge, either edge, or a held low or high level. Each input first passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with the level one cycle earlier.

A trigger code puts a pin in one of two groups. In a request code, the flag drives that pin's own request line, and the flag clears itself when the request consumer returns a done pulse. In an interrupt code, the flag feeds one shared interrupt line and stays set until software clears it.

Software can clear flags in two ways. It can write ones to a bank-wide status word, one bit per pin. It can also write the per-pin control word, where bit 24 is the flag bit. Reading a per-pin control word returns the flag at bit 24. The trigger codes are supplied from outside; this block does not store them.

Top module: `pin_event_detect`

## Requirements
- R1: After reset, every flag, the interrupt output and every request output are 0.
- R2: Edge codes set the flag on the third rising clock edge after the pin changes. The codes are 0001 (rising edge), 0010 (falling edge) and 0011 (either edge) in the request group, and 1001 (rising edge), 1010 (falling edge) and 1011 (either edge) in the interrupt group.
- R3: Code 1000 sets the flag while the synchronized pin is low, and code 1100 sets it while the synchronized pin is high.
- R4: Codes 0000, 0100 to 0111 and 1101 to 1111 never set a flag.
- R5: For a pin whose code is 0001, 0010 or 0011, its request output equals its flag, and that flag does not feed the interrupt output.
- R6: The interrupt output is the OR of the flags of all pins whose code is 1000 to 1100.
- R7: A done pulse on a pin in a request code clears that pin's flag on the next clock edge. A done pulse on a pin in any other code has no effect.
- R8: A status write clears the flag of every pin whose data bit is 1 and leaves the other flags unchanged.
- R9: A control-word write to pin k clears flag k only when data bit 24 is 1; when bit 24 is 0 the write has no effect. A control-word read of pin k returns flag k at bit 24 and 0 in every other bit.
- R10: If a level-code flag is cleared while its pin is still at the active level, the flag reads 1 on the next cycle.
- R11: If a set event and a clear arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| trig_cfg | input | 4*NUM_PINS | Trigger code per pin; pin i uses bits [4i+3:4i] |
| stat_wr | input | 1 | Status-word write strobe |
| stat_wr_data | input | NUM_PINS | Write-one-to-clear mask for the status word |
| ctl_wr | input | 1 | Per-pin control-word write strobe |
| ctl_wr_idx | input | IDX_W | Pin addressed by the control-word write |
| ctl_wr_data | input | 32 | Control-word write data; bit 24 clears the flag |
| ctl_rd_idx | input | IDX_W | Pin addressed by the control-word read |
| ctl_rd_word | output | 32 | Control-word read value; flag at bit 24 |
| req_done | input | NUM_PINS | Per-pin request-complete pulse |
| flags | output | NUM_PINS | Status-word view of all flags |
| irq | output | 1 | Shared interrupt |
| dma_req | output | NUM_PINS | Per-pin request lines |

## Verification
Every one of the 16 trigger codes is applied to all pins at once. The pins see the same sequence each time: held low and cleared, then a mixed mask of pins raised, cleared again, then dropped, then a done pulse on every pin. This pattern separates the edge codes from the level codes, separates the rising-edge codes from the falling-edge codes, and shows that the unlisted codes stay silent. The clear that arrives while a level is still active shows the flag re-setting. The done pulse shows that request-group flags clear and interrupt-group flags do not. Directed steps cover partial status masks, control-word clears with bit 24 set and with it clear, the read view of the control word, and a clear that arrives in the same cycle as an edge.

// File: rtl/ped_pkg.sv
package ped_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      TRIG_OFF      = 4'b0000,
      TRIG_DMA_RISE = 4'b0001,
      TRIG_DMA_FALL = 4'b0010,
      TRIG_DMA_BOTH = 4'b0011,
      TRIG_IRQ_LOW  = 4'b1000,
      TRIG_IRQ_RISE = 4'b1001,
      TRIG_IRQ_FALL = 4'b1010,
      TRIG_IRQ_BOTH = 4'b1011,
      TRIG_IRQ_HIGH = 4'b1100
   } trig_code_e;

   typedef struct packed {
      logic to_dma;
      logic to_irq;
      logic on_rise;
      logic on_fall;
      logic on_low;
      logic on_high;
   } trig_dec_t;

   function automatic trig_dec_t decode_trig(logic [CODE_W-1:0] code);
      trig_dec_t d;
      d = '0;
      case (code)
         TRIG_DMA_RISE: begin d.to_dma = 1'b1; d.on_rise = 1'b1; end
         TRIG_DMA_FALL: begin d.to_dma = 1'b1; d.on_fall = 1'b1; end
         TRIG_DMA_BOTH: begin d.to_dma = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
         TRIG_IRQ_LOW:  begin d.to_irq = 1'b1; d.on_low  = 1'b1; end
         TRIG_IRQ_RISE: begin d.to_irq = 1'b1; d.on_rise = 1'b1; end
         TRIG_IRQ_FALL: begin d.to_irq = 1'b1; d.on_fall = 1'b1; end
         TRIG_IRQ_BOTH: begin d.to_irq = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
         TRIG_IRQ_HIGH: begin d.to_irq = 1'b1; d.on_high = 1'b1; end
         default:       d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ped_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async};
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ped_clear_merge.sv
module ped_clear_merge #(
   parameter int NUM_PINS = 32,
   parameter int IDX_W    = 5,
   parameter int REG_W    = 32,
   parameter int CLR_BIT  = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stat_wr,
   input  logic [NUM_PINS-1:0] stat_wr_data,
   input  logic                ctl_wr,
   input  logic [IDX_W-1:0]    ctl_wr_idx,
   input  logic [REG_W-1:0]    ctl_wr_data,
   output logic [NUM_PINS-1:0] clr_vec
);

   generate
      if (CLR_BIT >= REG_W) begin : g_bad_bit
         $error("ped_clear_merge: CLR_BIT outside control word");
      end
   endgenerate

   logic [NUM_PINS-1:0] ctl_clr;
   logic [NUM_PINS-1:0] stat_clr;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         assign ctl_clr[gi]  = ctl_wr && (ctl_wr_idx == IDX_W'(gi)) && ctl_wr_data[CLR_BIT];
         assign stat_clr[gi] = stat_wr && stat_wr_data[gi];
      end
   endgenerate

   assign clr_vec = ctl_clr | stat_clr;

   // R9: a control-word write addresses at most one pin
   assert_ctl_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctl_clr));

   // R8: without a status write, only the control path may clear
   assert_stat_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |-> ((clr_vec & ~ctl_clr) == '0));

endmodule

// File: rtl/ped_pin_cell.sv
module ped_pin_cell
   import ped_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl,
   input  logic [CODE_W-1:0] code,
   input  logic              clr_sw,
   input  logic              done,
   output logic              flag,
   output logic              irq_src,
   output logic              dma_src
);

   trig_dec_t dec;
   logic      lvl_prev;
   logic      rise_evt;
   logic      fall_evt;
   logic      set_evt;
   logic      clr_evt;

   assign dec = decode_trig(code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl;
   end

   assign rise_evt = lvl & ~lvl_prev;
   assign fall_evt = ~lvl & lvl_prev;

   assign set_evt = (dec.on_rise & rise_evt) |
                    (dec.on_fall & fall_evt) |
                    (dec.on_low  & ~lvl)     |
                    (dec.on_high & lvl);

   assign clr_evt = clr_sw | (dec.to_dma & done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr_evt) flag <= 1'b0;
   end

   assign irq_src = flag & dec.to_irq;
   assign dma_src = flag & dec.to_dma;

   // R11: a set event wins over any clear in the same cycle
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);

   // R8: a clear with no set event drops the flag
   assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sw && !set_evt) |=> !flag);

   // R7: a done pulse clears a request-group flag
   assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dec.to_dma && !set_evt) |=> !flag);

   // R4: unlisted codes never raise a flag
   assert_unlisted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec.to_dma && !dec.to_irq && !flag) |=> !flag);

   // R2: a synchronized rising edge with a rising code sets the flag
   assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lvl) && dec.on_rise) |=> flag);

   // R3: an active high level with the high-level code sets the flag
   assert_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && dec.on_high) |=> flag);

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
   import ped_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 32,
   parameter int CLR_BIT     = 24,
   localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int CFG_W      = NUM_PINS * CODE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [CFG_W-1:0]    trig_cfg,
   input  logic                stat_wr,
   input  logic [NUM_PINS-1:0] stat_wr_data,
   input  logic                ctl_wr,
   input  logic [IDX_W-1:0]    ctl_wr_idx,
   input  logic [REG_W-1:0]    ctl_wr_data,
   input  logic [IDX_W-1:0]    ctl_rd_idx,
   output logic [REG_W-1:0]    ctl_rd_word,
   input  logic [NUM_PINS-1:0] req_done,
   output logic [NUM_PINS-1:0] flags,
   output logic                irq,
   output logic [NUM_PINS-1:0] dma_req
);

   generate
      if (NUM_PINS < 2 || NUM_PINS > REG_W) begin : g_bad_pins
         $error("pin_event_detect: NUM_PINS must be 2..REG_W");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_lvl;
   logic [NUM_PINS-1:0] clr_vec;
   logic [NUM_PINS-1:0] irq_vec;

   ped_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_lvl)
   );

   ped_clear_merge #(
      .NUM_PINS (NUM_PINS),
      .IDX_W    (IDX_W),
      .REG_W    (REG_W),
      .CLR_BIT  (CLR_BIT)
   ) u_clr (
      .clk          (clk),
      .rst_n        (rst_n),
      .stat_wr      (stat_wr),
      .stat_wr_data (stat_wr_data),
      .ctl_wr       (ctl_wr),
      .ctl_wr_idx   (ctl_wr_idx),
      .ctl_wr_data  (ctl_wr_data),
      .clr_vec      (clr_vec)
   );

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PINS; gp++) begin : g_cell
         ped_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (pin_lvl[gp]),
            .code    (trig_cfg[gp*CODE_W +: CODE_W]),
            .clr_sw  (clr_vec[gp]),
            .done    (req_done[gp]),
            .flag    (flags[gp]),
            .irq_src (irq_vec[gp]),
            .dma_src (dma_req[gp])
         );
      end
   endgenerate

   assign irq = |irq_vec;

   always_comb begin
      ctl_rd_word = '0;
      if (32'(ctl_rd_idx) < NUM_PINS)
         ctl_rd_word[CLR_BIT] = flags[ctl_rd_idx];
   end

   // R6: the interrupt is never raised without some flag set
   assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flags));

   // R5: a request line is only ever raised by a set flag
   assert_req_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((dma_req & ~flags) == '0));

endmodule

// File: tb/pin_event_detect_tb.sv
module pin_event_detect_tb;

   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [4*N-1:0] trig_cfg = '0;
   logic          stat_wr = 1'b0;
   logic [N-1:0]  stat_wr_data = '0;
   logic          ctl_wr = 1'b0;
   logic [4:0]    ctl_wr_idx = '0;
   logic [31:0]   ctl_wr_data = '0;
   logic [4:0]    ctl_rd_idx = '0;
   logic [31:0]   ctl_rd_word;
   logic [N-1:0]  req_done = '0;
   logic [N-1:0]  flags;
   logic          irq;
   logic [N-1:0]  dma_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pin_event_detect u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_in       (pin_in),
      .trig_cfg     (trig_cfg),
      .stat_wr      (stat_wr),
      .stat_wr_data (stat_wr_data),
      .ctl_wr       (ctl_wr),
      .ctl_wr_idx   (ctl_wr_idx),
      .ctl_wr_data  (ctl_wr_data),
      .ctl_rd_idx   (ctl_rd_idx),
      .ctl_rd_word  (ctl_rd_word),
      .req_done     (req_done),
      .flags        (flags),
      .irq          (irq),
      .dma_req      (dma_req)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   function automatic bit is_rise(int c);  return c == 1 || c == 3 || c == 9  || c == 11; endfunction
   function automatic bit is_fall(int c);  return c == 2 || c == 3 || c == 10 || c == 11; endfunction
   function automatic bit is_dma(int c);   return c >= 1 && c <= 3; endfunction
   function automatic bit is_int(int c);   return c >= 8 && c <= 12; endfunction

   function automatic string tag_of(int c);
      if (c == 8 || c == 12) return "R3";
      if (is_dma(c) || is_int(c)) return "R2";
      return "R4";
   endfunction

   task automatic clear_all();
      stat_wr = 1'b1; stat_wr_data = '1;
      tick();
      stat_wr = 1'b0; stat_wr_data = '0;
   endtask

   task automatic chk_outs(int c, string tg, logic [31:0] e);
      chk(tg, $sformatf("flags code %0d", c), flags, e);
      chk("R6", $sformatf("irq code %0d", c), {31'b0, irq}, {31'b0, is_int(c) && (|e)});
      chk("R5", $sformatf("dma_req code %0d", c), dma_req, is_dma(c) ? e : 32'h0);
   endtask

   initial begin
      logic [31:0] m;
      logic [31:0] e;
      m = 32'hA5A5_3C3C;

      repeat (3) tick();
      // R1: reset state
      chk("R1", "flags at reset", flags, 32'h0);
      chk("R1", "irq at reset", {31'b0, irq}, 32'h0);
      chk("R1", "dma_req at reset", dma_req, 32'h0);
      rst_n = 1'b1;
      tick();

      for (int c = 0; c < 16; c++) begin
         trig_cfg = {N{c[3:0]}};
         pin_in = '0;
         repeat (4) tick();
         clear_all();
         // R10: low-level code re-sets right after a clear
         chk(c == 8 ? "R10" : "R8", $sformatf("after clear code %0d", c), flags,
             c == 8 ? 32'hFFFF_FFFF : 32'h0);

         pin_in = m;
         repeat (3) tick();
         e = (is_rise(c) ? m : 32'h0) | (c == 8 ? 32'hFFFF_FFFF : 32'h0) | (c == 12 ? m : 32'h0);
         chk_outs(c, tag_of(c), e);

         clear_all();
         e = (c == 8) ? ~m : (c == 12) ? m : 32'h0;
         chk(c == 8 || c == 12 ? "R10" : "R8", $sformatf("mid clear code %0d", c), flags, e);

         pin_in = '0;
         repeat (3) tick();
         e = (is_fall(c) ? m : 32'h0) | (c == 8 ? 32'hFFFF_FFFF : 32'h0) | (c == 12 ? m : 32'h0);
         chk_outs(c, tag_of(c), e);

         req_done = '1;
         tick();
         req_done = '0;
         chk("R7", $sformatf("after done code %0d", c), flags, is_dma(c) ? 32'h0 : e);
      end

      // Status and control-word clears with code 1001 on all pins
      trig_cfg = {N{4'b1001}};
      pin_in = '0;
      repeat (3) tick();
      clear_all();
      pin_in = '1;
      repeat (3) tick();
      chk("R2", "all pins rise", flags, 32'hFFFF_FFFF);
      stat_wr = 1'b1; stat_wr_data = 32'h0000_FFFF;
      tick();
      stat_wr = 1'b0; stat_wr_data = '0;
      chk("R8", "partial status clear", flags, 32'hFFFF_0000);

      ctl_wr = 1'b1; ctl_wr_idx = 5'd20; ctl_wr_data = 32'h0100_0000;
      tick();
      ctl_wr = 1'b0;
      chk("R9", "control clear pin 20", flags, 32'hFFEF_0000);

      ctl_wr = 1'b1; ctl_wr_idx = 5'd21; ctl_wr_data = 32'hFEFF_FFFF;
      tick();
      ctl_wr = 1'b0; ctl_wr_data = '0;
      chk("R9", "control write bit24 zero", flags, 32'hFFEF_0000);

      ctl_rd_idx = 5'd21;
      #1;
      chk("R9", "read view pin 21", ctl_rd_word, 32'h0100_0000);
      ctl_rd_idx = 5'd20;
      #1;
      chk("R9", "read view pin 20", ctl_rd_word, 32'h0000_0000);

      // R11: edge and clear in the same cycle
      pin_in = '0;
      repeat (3) tick();
      clear_all();
      chk("R8", "cleared before race", flags, 32'h0);
      pin_in = 32'h0000_0008;
      tick();
      tick();
      stat_wr = 1'b1; stat_wr_data = 32'h0000_0008;
      tick();
      stat_wr = 1'b0; stat_wr_data = '0;
      chk("R11", "set beats clear", flags, 32'h0000_0008);
      chk("R6", "irq after race", {31'b0, irq}, 32'h1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule